// File: doc/BRIEF.md
# Dual-Channel Output Switch Controller

This block holds the control state for two output driver channels and turns it into gate commands. Each channel has a high-side gate and a low-side gate. A host programs the block over a plain parallel register port with an address, write data, a write strobe and combinational read data. Two external pins feed the decision: a shared output-enable pin and a transmit-data pin. Both pass through a two-flop synchronizer.

For each channel, the block chooses a data source: a register bit or the transmit pin. It can invert that data, and it works out whether the channel is enabled. The enable is a per-channel register bit, gated by the shared pin. In register mode and pin mode the pin gates both channels. In mixed mode it gates only the channel whose data comes from the transmit pin. The resulting bit is mapped onto the chosen driver topology (off, low-side, high-side or push-pull) and registered onto the gate outputs.

Top module: `dual_switch_ctrl`

## Requirements
- R1: After reset, address 0x00 reads 0x10 (source select = 01, register data = 00), address 0x01 reads 0xF0 (both topologies push-pull), and addresses 0x02 and 0x03 read 0x00.
- R2: Register fields are: source select at 0x00 bits 5:4; register data at 0x00 bits 1:0; channel 1 topology at 0x01 bits 5:4; channel 2 topology at 0x01 bits 7:6; enable bits at 0x02 bits 1:0; invert bits at 0x03 bits 5:4. Every other bit reads 0 and ignores writes. Any other address reads 0x00, and writes to it change nothing.
- R3: For a channel whose source-select bit is 0, the data is its register data bit. When that bit is 1, the data is the synchronized transmit pin. Bit 0 of each field belongs to channel 1 and bit 1 to channel 2.
- R4: When a channel's invert bit is 1, its data is inverted after source selection.
- R5: A channel whose enable bit is 0 drives both gates off, whatever the pins do.
- R6: When source select is 00 or 11, each channel is enabled only if its enable bit and the synchronized enable pin are both 1.
- R7: When source select is 01 or 10, the enable pin gates only the channel whose select bit is 1. The other channel is enabled by its enable bit alone.
- R8: Topology codes are 00 = off, 01 = low-side, 10 = high-side and 11 = push-pull. An enabled channel drives gates as follows. In push-pull, data 1 gives high-side on and data 0 gives low-side on. In high-side, data 1 gives high-side on. In low-side, data 1 gives low-side on. All other cases give both gates off.
- R9: The high-side and low-side gates of one channel are never on together.
- R10: A register write strobed at clock edge k shows on the gates at edge k+1. A pin change shows on the gates at the third rising edge after it.
- R11: While reset is asserted and after it is released, all gates are off until enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| tx_i | input | 1 | Transmit-data pin, asynchronous |
| oen_i | input | 1 | Shared output-enable pin, asynchronous |
| hs_o | output | 2 | High-side gate command per channel |
| ls_o | output | 2 | Low-side gate command per channel |

## Verification
Read data is due in the same cycle, so the bench samples it one time step after it sets the address. A register write strobed at an edge changes the gates at the next edge. A pin change needs two synchronizer edges plus the output edge. For that reason the bench samples the gates at the falling edge after the third rising edge, once every setting and pin combination has been applied. Dedicated checks sample one edge early to confirm that the gates have not yet moved, then sample again at the due edge.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;
  typedef enum logic [1:0] {
    TOPO_OFF = 2'b00,
    TOPO_LS  = 2'b01,
    TOPO_HS  = 2'b10,
    TOPO_PP  = 2'b11
  } topo_e;

  localparam logic [7:0] ADR_CTRL = 8'h00;
  localparam logic [7:0] ADR_TOPO = 8'h01;
  localparam logic [7:0] ADR_EN   = 8'h02;
  localparam logic [7:0] ADR_INV  = 8'h03;

  localparam int SEL_LSB  = 4;
  localparam int DATA_LSB = 0;
  localparam int TOPO_LSB = 4;
  localparam int EN_LSB   = 0;
  localparam int INV_LSB  = 4;
endpackage

// File: rtl/swc_sync.sv
`timescale 1ns/1ps
module swc_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/swc_regs.sv
`timescale 1ns/1ps
module swc_regs
  import swc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [NUM_CH-1:0] SEL_RST = NUM_CH'(1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   we_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [NUM_CH-1:0]      sel_o,
  output logic [NUM_CH-1:0]      dat_o,
  output logic [NUM_CH-1:0]      en_o,
  output logic [NUM_CH-1:0]      inv_o,
  output logic [NUM_CH-1:0][1:0] topo_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_TOPO = ADDR_W'(ADR_TOPO);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADR_EN);
  localparam logic [ADDR_W-1:0] A_INV  = ADDR_W'(ADR_INV);

  logic [NUM_CH-1:0]      sel_q, dat_q, en_q, inv_q;
  logic [NUM_CH-1:0][1:0] topo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SEL_RST;
      dat_q  <= '0;
      en_q   <= '0;
      inv_q  <= '0;
      topo_q <= {NUM_CH{TOPO_PP}};
    end else if (we_i) begin
      unique case (addr_i)
        A_CTRL: begin
          sel_q <= wdata_i[SEL_LSB +: NUM_CH];
          dat_q <= wdata_i[DATA_LSB +: NUM_CH];
        end
        A_TOPO: begin
          for (int c = 0; c < NUM_CH; c++)
            topo_q[c] <= wdata_i[TOPO_LSB + 2*c +: 2];
        end
        A_EN:  en_q  <= wdata_i[EN_LSB +: NUM_CH];
        A_INV: inv_q <= wdata_i[INV_LSB +: NUM_CH];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[SEL_LSB +: NUM_CH]  = sel_q;
        rdata_o[DATA_LSB +: NUM_CH] = dat_q;
      end
      A_TOPO: begin
        for (int c = 0; c < NUM_CH; c++)
          rdata_o[TOPO_LSB + 2*c +: 2] = topo_q[c];
      end
      A_EN:  rdata_o[EN_LSB +: NUM_CH]  = en_q;
      A_INV: rdata_o[INV_LSB +: NUM_CH] = inv_q;
      default: ;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign sel_o  = sel_q;
  assign dat_o  = dat_q;
  assign en_o   = en_q;
  assign inv_o  = inv_q;
  assign topo_o = topo_q;
endmodule

// File: rtl/swc_chan.sv
`timescale 1ns/1ps
module swc_chan
  import swc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       data_i,
  input  logic [1:0] topo_i,
  output logic       hs_o,
  output logic       ls_o
);
  logic hs_d, ls_d, hs_q, ls_q;

  always_comb begin
    hs_d = 1'b0;
    ls_d = 1'b0;
    if (en_i) begin
      unique case (topo_e'(topo_i))
        TOPO_PP: begin hs_d = data_i; ls_d = ~data_i; end
        TOPO_HS: hs_d = data_i;
        TOPO_LS: ls_d = data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;
endmodule

// File: rtl/dual_switch_ctrl.sv
`timescale 1ns/1ps
module dual_switch_ctrl #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_i,
  input  logic              oen_i,
  output logic [NUM_CH-1:0] hs_o,
  output logic [NUM_CH-1:0] ls_o
);
  logic [NUM_CH-1:0]      sel_q, dat_q, oen_q, inv_q;
  logic [NUM_CH-1:0][1:0] topo_q;
  logic [1:0]             pins_s;
  logic                   tx_s, oen_s;
  logic                   common_gate;

  swc_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .sel_o(sel_q), .dat_o(dat_q),
    .en_o(oen_q), .inv_o(inv_q), .topo_o(topo_q)
  );

  swc_sync #(.WIDTH(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({oen_i, tx_i}), .q_o(pins_s)
  );
  assign tx_s  = pins_s[0];
  assign oen_s = pins_s[1];

  // all-register mode gates every channel with the pin, like all-pin mode
  assign common_gate = (sel_q == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic pin_gated, en, data;
    assign pin_gated = sel_q[c] | common_gate;
    assign en        = oen_q[c] & (~pin_gated | oen_s);
    assign data      = (sel_q[c] ? tx_s : dat_q[c]) ^ inv_q[c];

    swc_chan u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .data_i(data),
      .topo_i(topo_q[c]), .hs_o(hs_o[c]), .ls_o(ls_o[c])
    );
  end
endmodule

// File: rtl/dual_switch_ctrl_chk.sv
`timescale 1ns/1ps
module dual_switch_ctrl_chk
  import swc_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [DATA_W-1:0]      rdata_o,
  input logic [NUM_CH-1:0]      hs_o,
  input logic [NUM_CH-1:0]      ls_o,
  input logic [NUM_CH-1:0]      oen_q,
  input logic [NUM_CH-1:0][1:0] topo_q
);
  localparam logic [DATA_W-1:0] FMASK = DATA_W'((1 << NUM_CH) - 1);
  localparam logic [DATA_W-1:0] CTRL_USED = (FMASK << SEL_LSB) | (FMASK << DATA_LSB);

  p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_o & ls_o) == '0);

  p_ctrl_unused_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(ADR_CTRL)) |-> ((rdata_o & ~CTRL_USED) == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_en_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oen_q[c] |=> (!hs_o[c] && !ls_o[c]));
    p_topo_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (topo_q[c] == TOPO_OFF) |=> (!hs_o[c] && !ls_o[c]));
    p_hs_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (topo_q[c] == TOPO_HS) |=> !ls_o[c]);
    p_ls_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (topo_q[c] == TOPO_LS) |=> !hs_o[c]);
  end
endmodule

bind dual_switch_ctrl dual_switch_ctrl_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rdata_o(rdata_o),
  .hs_o(hs_o), .ls_o(ls_o), .oen_q(oen_q), .topo_q(topo_q)
);

// File: tb/tb_dual_switch_ctrl.sv
`timescale 1ns/1ps
module tb_dual_switch_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       we = 1'b0, tx = 1'b0, oen = 1'b0;
  logic [1:0] hs, ls;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_switch_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .tx_i(tx), .oen_i(oen), .hs_o(hs), .ls_o(ls)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  // gate model from R3..R8: returns {hs[1:0], ls[1:0]}
  function automatic logic [3:0] model(input logic [1:0] sel, input logic [1:0] dat,
      input logic [1:0] en, input logic [1:0] inv, input logic [1:0] t1, input logic [1:0] t2,
      input logic txp, input logic oenp);
    logic [1:0] h = '0, l = '0;
    for (int c = 0; c < 2; c++) begin
      logic gated, e, d;
      logic [1:0] t;
      t = (c == 0) ? t1 : t2;
      gated = (sel == 2'b00) || (sel == 2'b11) || sel[c];
      e = en[c] && (!gated || oenp);
      d = (sel[c] ? txp : dat[c]) ^ inv[c];
      if (e) begin
        if (t == 2'b11) begin h[c] = d; l[c] = !d; end
        else if (t == 2'b10) h[c] = d;
        else if (t == 2'b01) l[c] = d;
      end
    end
    return {h, l};
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 gates in reset", {4'h0, hs, ls}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 gates after reset", {4'h0, hs, ls}, 8'h00);
    rd_check("R1 ctrl reset", 8'h00, 8'h10);
    rd_check("R1 topo reset", 8'h01, 8'hF0);
    rd_check("R1 en reset", 8'h02, 8'h00);
    rd_check("R1 inv reset", 8'h03, 8'h00);

    // R2 reserved bits and unmapped address
    wr(8'h00, 8'hFF); wr(8'h01, 8'hFF); wr(8'h02, 8'hFF); wr(8'h03, 8'hFF);
    wr(8'h04, 8'hFF); wr(8'hA7, 8'h55);
    rd_check("R2 ctrl mask", 8'h00, 8'h33);
    rd_check("R2 topo mask", 8'h01, 8'hF0);
    rd_check("R2 en mask", 8'h02, 8'h03);
    rd_check("R2 inv mask", 8'h03, 8'h30);
    rd_check("R2 unmapped 04", 8'h04, 8'h00);
    rd_check("R2 unmapped A7", 8'hA7, 8'h00);

    // R10 pin latency: pin mode, push-pull, enabled, no invert
    wr(8'h00, 8'h30); wr(8'h03, 8'h00); wr(8'h01, 8'hF0); wr(8'h02, 8'h03);
    oen = 1'b1; tx = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 pin baseline", {4'h0, hs, ls}, 8'h03);
    tx = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 pin not yet", {4'h0, hs, ls}, 8'h03);
    @(negedge clk);
    check("R10 pin due", {4'h0, hs, ls}, 8'h0C);
    // R10 register latency
    wr(8'h02, 8'h00);
    check("R10 reg not yet", {4'h0, hs, ls}, 8'h0C);
    @(negedge clk);
    check("R10 reg due", {4'h0, hs, ls}, 8'h00);

    // exhaustive sweep: R3 source, R4 invert, R5 enable, R6 common gate, R7 mixed gate, R8 topology, R9 overlap
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        for (int e = 0; e < 4; e++)
          for (int iv = 0; iv < 4; iv++)
            for (int tp = 0; tp < 16; tp++) begin
              wr(8'h00, {2'b00, 2'(s), 2'b00, 2'(d)});
              wr(8'h01, {2'(tp >> 2), 2'(tp), 4'h0});
              wr(8'h02, {6'h0, 2'(e)});
              wr(8'h03, {2'b00, 2'(iv), 4'h0});
              for (int p = 0; p < 4; p++) begin
                logic [3:0] exp;
                tx = p[0]; oen = p[1];
                repeat (3) @(posedge clk);
                @(negedge clk);
                exp = model(2'(s), 2'(d), 2'(e), 2'(iv), 2'(tp), 2'(tp >> 2), p[0], p[1]);
                check("R3/R4/R5/R6/R7/R8 gates", {4'h0, hs, ls}, {4'h0, exp});
                check("R9 no overlap", {6'h0, hs & ls}, 8'h00);
              end
            end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule